// File: doc/BRIEF.md
# Cascadable Dual 8-bit Down-Counter Pair

The block holds two 8-bit down-counters. Each one reloads from its own reload value when it counts past zero. A configuration bit joins the two into one 16-bit down-counter. In that 16-bit mode, timer 0 supplies the low byte and timer 1 the high byte. Timer 1 then advances only when timer 0 wraps, and the run, clock-enable and event settings of timer 0 govern the whole pair.

Each timer produces three outputs:
- a one-cycle underflow interrupt pulse;
- a compare-driven PWM wave;
- a square wave that toggles on every underflow.

One of these waveforms, with a polarity inversion applied, drives a single timer output. The prescaler, pin multiplexing and interrupt controller are outside the block. Count pacing enters as per-timer clock-enable inputs.

Software reads the 16-bit count through a 4-bit readout port. In 16-bit mode, reading the lowest nibble freezes the upper twelve bits in a snapshot. The three upper nibbles can then be read in any order without tearing, while the counter keeps running.

Top module: `tmr_pair`

## Requirements
- R1: In 8-bit mode (chain_i=0), timer k counts on each cycle where run_i[k] is 1 and its source is 1. The source is clk_en_i[k], or the event edge when evmode_i[k] is 1. On such a cycle a count of 0 reloads from the timer's reload value; any other count decrements by one. On other cycles the count holds.
- R2: load_i[k] copies the reload value into counter k. It takes precedence over counting and clears that timer's PWM state. The strobe for each timer is independent of the other.
- R3: With chain_i=1, the count is {timer1,timer0}. Timer 0 follows the rules of R1. Timer 1 counts (decrement, or reload at 0) only in cycles where timer 0 underflows. run_i[1], clk_en_i[1] and evmode_i[1] have no effect in this mode.
- R4: In event mode the source is an edge of evt_i[k] after a two-flop synchronizer: rising when evfall_i[k]=0, falling when evfall_i[k]=1. The counter changes on the third rising clock edge after evt_i changes.
- R5: irq_o[k] is high for one cycle, in the cycle after timer k underflows (it counted at 0 without a load). In 16-bit mode, irq_o[1] marks a wrap of the full 16-bit count, and irq_o[0] is high in that cycle too.
- R6: Each timer has a PWM state. It goes to 1 on a counting cycle where the count equals the compare value and no underflow happens. It goes to 0 on underflow or load. In 16-bit mode, timer 1 compares {cmp1_i,cmp0_i} with the 16-bit count on timer 0's counting cycles. Each timer also has a toggle state that flips on each of its underflows.
- R7: One cycle later, tout_o equals the selected timer's wave XOR pol_i of that timer. The wave is the PWM state when pwm_en_i is 1, otherwise the toggle state. osel_i=1 selects timer 1 and osel_i=0 selects timer 0. In 16-bit mode, timer 1 and its settings are always used and osel_i has no effect.
- R8: A read (rd_i=1) loads rd_data_o, on the next clock edge, with nibble rd_sel_i of {timer1,timer0}. Nibble 0 is bits 3..0 and nibble 3 is bits 15..12. rd_data_o holds between reads. In 8-bit mode every read returns live data.
- R9: In 16-bit mode, a read of nibble 0 returns live bits 3..0 and captures bits 15..4. Later reads of nibbles 1 to 3 return the captured bits until the next read of nibble 0.
- R10: In 16-bit mode, a read of nibbles 1 to 3 returns live data when there has been no nibble-0 read since reset or since chain_i was last 0.
- R11: After reset, both counters, PWM and toggle states, rd_data_o, irq_o and tout_o are 0, and no capture is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chain_i | input | 1 | 1 joins the pair into a 16-bit counter |
| run_i | input | 2 | Run enable per timer |
| clk_en_i | input | 2 | Count pacing enable per timer |
| evmode_i | input | 2 | 1 counts external edges instead of clk_en_i |
| evfall_i | input | 2 | Event edge select, 1 = falling |
| evt_i | input | 2 | Asynchronous external event inputs |
| load_i | input | 2 | Reload strobe per timer |
| rld0_i | input | 8 | Reload value, timer 0 |
| rld1_i | input | 8 | Reload value, timer 1 |
| cmp0_i | input | 8 | Compare value, timer 0 |
| cmp1_i | input | 8 | Compare value, timer 1 |
| pwm_en_i | input | 2 | 1 selects PWM wave, 0 selects toggle wave |
| pol_i | input | 2 | Output inversion per timer |
| osel_i | input | 1 | Output source in 8-bit mode, 1 = timer 1 |
| rd_i | input | 1 | Readout strobe |
| rd_sel_i | input | 2 | Nibble index of the readout |
| rd_data_o | output | 4 | Registered readout nibble |
| irq_o | output | 2 | Underflow pulses per timer |
| tout_o | output | 1 | Registered timer output |

## Verification
Two events often meet in one cycle. A nibble-0 read can take its snapshot in the same cycle as a low-byte wrap that carries into the high byte. A compare match can also fall on an underflow, as when the compare value is 0. The bench provokes both. It uses short reload values at full clock-enable rate, so wraps are frequent, and issues dense random reads. A directed run sets the compare values to zero. A cycle-level model judges the result. It is written from the requirements and expects the snapshot to hold the pre-edge count, and expects an underflow to win over a match.

// File: rtl/tp_pkg.sv
package tp_pkg;
  localparam int TP_NIB = 4;
  localparam int TP_SYNC = 2;

  typedef struct packed {
    logic pwm;
    logic tgl;
  } tp_wave_t;
endpackage

// File: rtl/tp_evsync.sv
module tp_evsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic evt_i,
  input  logic fall_i,
  output logic edge_o
);
  logic [STAGES:0] sh_q;
  logic cur, prev;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-1:0], evt_i};
  end

  always_comb begin
    cur    = sh_q[STAGES-1];
    prev   = sh_q[STAGES];
    edge_o = fall_i ? (prev & ~cur) : (cur & ~prev);
  end
endmodule

// File: rtl/tp_cnt8.sv
module tp_cnt8 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic [W-1:0] rld_i,
  output logic [W-1:0] cnt_o,
  output logic         uf_o
);
  logic [W-1:0] cnt_q;

  assign cnt_o = cnt_q;
  assign uf_o  = tick_i & ~load_i & (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (load_i) cnt_q <= rld_i;
    else if (tick_i) cnt_q <= (cnt_q == '0) ? rld_i : cnt_q - 1'b1;
  end

  AST_RELOAD_ON_UF: assert property (@(posedge clk) disable iff (rst)
    uf_o |=> cnt_o == $past(rld_i)); // R1
  AST_DECREMENT: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !load_i && cnt_o != '0) |=> cnt_o == W'($past(cnt_o) - 1'b1)); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !load_i) |=> $stable(cnt_o)); // R1
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    load_i |=> cnt_o == $past(rld_i)); // R2
endmodule

// File: rtl/tp_wave.sv
module tp_wave (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic match_i,
  input  logic uf_i,
  input  logic load_i,
  output tp_pkg::tp_wave_t wave_o
);
  tp_pkg::tp_wave_t w_q;

  assign wave_o = w_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      w_q <= '0;
    end else begin
      if (load_i || uf_i)          w_q.pwm <= 1'b0;
      else if (tick_i && match_i)  w_q.pwm <= 1'b1;
      if (uf_i)                    w_q.tgl <= ~w_q.tgl;
    end
  end

  AST_WAVE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (uf_i || load_i) |=> !wave_o.pwm); // R6
  AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (rst)
    uf_i |=> wave_o.tgl != $past(wave_o.tgl)); // R6
endmodule

// File: rtl/tp_rdlatch.sv
module tp_rdlatch #(
  parameter int DW = 16,
  parameter int NW = 4,
  localparam int NN = DW / NW,
  localparam int SW = $clog2(NN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_i,
  input  logic          rd_i,
  input  logic [SW-1:0] sel_i,
  input  logic [DW-1:0] live_i,
  output logic [NW-1:0] data_o
);
  logic [DW-1:NW] hold_q;
  logic           vld_q;
  logic [DW-1:0]  held_full;
  logic [NW-1:0]  nib_live, nib_held;

  always_comb begin
    held_full = {hold_q, live_i[NW-1:0]};
    nib_live  = live_i[int'(sel_i)*NW +: NW];
    nib_held  = held_full[int'(sel_i)*NW +: NW];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      vld_q  <= 1'b0;
      data_o <= '0;
    end else begin
      if (!en_i) vld_q <= 1'b0;
      if (rd_i) begin
        if (en_i && sel_i == '0) begin
          data_o <= live_i[NW-1:0];
          hold_q <= live_i[DW-1:NW];
          vld_q  <= 1'b1;
        end else if (en_i && vld_q) begin
          data_o <= nib_held;
        end else begin
          data_o <= nib_live;
        end
      end
    end
  end

  AST_SNAP_STABLE: assert property (@(posedge clk) disable iff (rst)
    (vld_q && en_i && !(rd_i && sel_i == '0)) |=> $stable(hold_q)); // R9
  AST_NO_SNAP_OFF: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !vld_q); // R10
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> $stable(data_o)); // R8
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair #(
  parameter int W = 8,
  parameter int NIB = tp_pkg::TP_NIB,
  parameter int SYNC = tp_pkg::TP_SYNC,
  localparam int DW = 2 * W,
  localparam int SW = $clog2(DW / NIB)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          chain_i,
  input  logic [1:0]    run_i,
  input  logic [1:0]    clk_en_i,
  input  logic [1:0]    evmode_i,
  input  logic [1:0]    evfall_i,
  input  logic [1:0]    evt_i,
  input  logic [1:0]    load_i,
  input  logic [W-1:0]  rld0_i,
  input  logic [W-1:0]  rld1_i,
  input  logic [W-1:0]  cmp0_i,
  input  logic [W-1:0]  cmp1_i,
  input  logic [1:0]    pwm_en_i,
  input  logic [1:0]    pol_i,
  input  logic          osel_i,
  input  logic          rd_i,
  input  logic [SW-1:0] rd_sel_i,
  output logic [NIB-1:0] rd_data_o,
  output logic [1:0]    irq_o,
  output logic          tout_o
);
  logic [1:0]         edg, src, tick, uf, match, wtick;
  logic [1:0][W-1:0]  cnt, rld;
  tp_pkg::tp_wave_t   wave [2];
  logic [DW-1:0]      full;
  logic               osel_eff, out_raw;

  assign rld = {rld1_i, rld0_i};

  for (genvar k = 0; k < 2; k++) begin : g_tmr
    tp_evsync #(.STAGES(SYNC)) u_sync (
      .clk(clk), .rst(rst), .evt_i(evt_i[k]), .fall_i(evfall_i[k]), .edge_o(edg[k])
    );
    tp_cnt8 #(.W(W)) u_cnt (
      .clk(clk), .rst(rst), .tick_i(tick[k]), .load_i(load_i[k]),
      .rld_i(rld[k]), .cnt_o(cnt[k]), .uf_o(uf[k])
    );
    tp_wave u_wave (
      .clk(clk), .rst(rst), .tick_i(wtick[k]), .match_i(match[k]),
      .uf_i(uf[k]), .load_i(load_i[k]), .wave_o(wave[k])
    );
  end

  always_comb begin
    for (int k = 0; k < 2; k++)
      src[k] = run_i[k] & (evmode_i[k] ? edg[k] : clk_en_i[k]);
    full     = {cnt[1], cnt[0]};
    tick[0]  = src[0];
    tick[1]  = chain_i ? uf[0] : src[1];
    wtick[0] = tick[0];
    wtick[1] = chain_i ? tick[0] : tick[1];
    match[0] = (cnt[0] == cmp0_i);
    match[1] = chain_i ? (full == {cmp1_i, cmp0_i}) : (cnt[1] == cmp1_i);
    osel_eff = chain_i | osel_i;
    out_raw  = (pwm_en_i[osel_eff] ? wave[osel_eff].pwm : wave[osel_eff].tgl)
               ^ pol_i[osel_eff];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o  <= '0;
      tout_o <= 1'b0;
    end else begin
      irq_o  <= uf;
      tout_o <= out_raw;
    end
  end

  tp_rdlatch #(.DW(DW), .NW(NIB)) u_rd (
    .clk(clk), .rst(rst), .en_i(chain_i), .rd_i(rd_i), .sel_i(rd_sel_i),
    .live_i(full), .data_o(rd_data_o)
  );

  AST_UPPER_GATED: assert property (@(posedge clk) disable iff (rst)
    (chain_i && !uf[0] && !load_i[1]) |=> $stable(cnt[1])); // R3
  AST_CHAIN_IRQ: assert property (@(posedge clk) disable iff (rst)
    (chain_i && $past(chain_i) && irq_o[1]) |-> irq_o[0]); // R5
endmodule

// File: tb/sim_tmr_pair.sv
module sim_tmr_pair;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic chain = 0, osel = 0, rd = 0;
  logic [1:0] run = 0, cen = 0, evm = 0, evf = 0, evt = 0, load = 0, pwen = 0, pol = 0;
  logic [7:0] rld0 = 0, rld1 = 0, cmp0 = 0, cmp1 = 0;
  logic [1:0] rsel = 0;
  logic [3:0] rdat;
  logic [1:0] irq;
  logic tout;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  string ptag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_pair u0 (
    .clk(clk), .rst(rst), .chain_i(chain), .run_i(run), .clk_en_i(cen),
    .evmode_i(evm), .evfall_i(evf), .evt_i(evt), .load_i(load),
    .rld0_i(rld0), .rld1_i(rld1), .cmp0_i(cmp0), .cmp1_i(cmp1),
    .pwm_en_i(pwen), .pol_i(pol), .osel_i(osel), .rd_i(rd), .rd_sel_i(rsel),
    .rd_data_o(rdat), .irq_o(irq), .tout_o(tout)
  );

  // Reference model built from the requirements
  logic [7:0] m_c0, m_c1;
  logic [1:0] m_p, m_t, m_irq;
  logic [2:0] m_s0, m_s1;
  logic m_tout, m_vld;
  logic [3:0] m_rd;
  logic [11:0] m_hold;
  string m_rtag = "R11";

  function automatic logic edge_of(input logic [2:0] s, input logic fall);
    return fall ? (s[2] & ~s[1]) : (s[1] & ~s[2]);
  endfunction

  function automatic logic [7:0] next_cnt(input logic [7:0] c, input logic ld,
                                          input logic tk, input logic [7:0] r);
    if (ld) return r;
    if (tk) return (c == 0) ? r : c - 8'd1;
    return c;
  endfunction

  always @(posedge clk) begin : model
    logic [1:0] src;
    logic t0, t1, uf0, uf1, mt0, mt1, wt1, sel;
    logic [15:0] f;
    logic [3:0] nl;
    if (rst) begin
      m_c0 = 0; m_c1 = 0; m_p = 0; m_t = 0; m_irq = 0; m_s0 = 0; m_s1 = 0;
      m_tout = 0; m_vld = 0; m_rd = 0; m_hold = 0;
    end else begin
      src[0] = run[0] & (evm[0] ? edge_of(m_s0, evf[0]) : cen[0]);
      src[1] = run[1] & (evm[1] ? edge_of(m_s1, evf[1]) : cen[1]);
      t0 = src[0];
      uf0 = t0 && !load[0] && m_c0 == 0;
      t1 = chain ? uf0 : src[1];
      uf1 = t1 && !load[1] && m_c1 == 0;
      f = {m_c1, m_c0};
      mt0 = (m_c0 == cmp0);
      mt1 = chain ? (f == {cmp1, cmp0}) : (m_c1 == cmp1);
      wt1 = chain ? t0 : t1;
      sel = chain | osel;
      m_tout = (pwen[sel] ? m_p[sel] : m_t[sel]) ^ pol[sel];
      m_irq = {uf1, uf0};
      nl = f[rsel*4 +: 4];
      if (rd) begin
        if (chain && rsel == 0) begin
          m_rd = nl; m_hold = f[15:4]; m_vld = 1; m_rtag = "R9";
        end else if (chain && m_vld) begin
          m_rd = {m_hold, 4'h0} >> (rsel*4); m_rtag = "R9";
        end else begin
          m_rd = nl; m_rtag = chain ? "R10" : "R8";
        end
      end
      if (!chain) m_vld = 0;
      if (load[0] || uf0) m_p[0] = 0; else if (t0 && mt0) m_p[0] = 1;
      if (load[1] || uf1) m_p[1] = 0; else if (wt1 && mt1) m_p[1] = 1;
      if (uf0) m_t[0] = ~m_t[0];
      if (uf1) m_t[1] = ~m_t[1];
      m_c0 = next_cnt(m_c0, load[0], t0, rld0);
      m_c1 = next_cnt(m_c1, load[1], t1, rld1);
      m_s0 = {m_s0[1:0], evt[0]};
      m_s1 = {m_s1[1:0], evt[1]};
    end
  end

  task automatic chk(input string tag, input string what, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    chk("R5", "irq_o", {2'b0, irq}, {2'b0, m_irq});
    chk("R6/R7", "tout_o", {3'b0, tout}, {3'b0, m_tout});
    chk({m_rtag, " ", ptag}, "rd_data_o", rdat, m_rd);
    load = 0; rd = 0;
  endtask

  task automatic rdn(input int s);
    rd = 1; rsel = 2'(s);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (4) @(negedge clk);
    rst = 0;
    ptag = "R11";
    cyc();
    chk("R11", "reset rd_data_o", rdat, 4'h0);
    chk("R11", "reset irq_o", {2'b0, irq}, 4'h0);
    chk("R11", "reset tout_o", {3'b0, tout}, 4'h0);

    // R1/R2: 8-bit timers, independent loads
    ptag = "R1 R2";
    rld0 = 8'h05; rld1 = 8'h23; cmp0 = 8'h02; pwen = 2'b01; run = 2'b11; cen = 2'b01;
    load = 2'b11; cyc();
    for (int i = 0; i < 30; i++) begin
      if (i % 3 == 0) rdn(i % 4);
      cen[1] = (i % 2 == 0);
      cyc();
    end

    // R3/R9: chained, snapshot while counting fast; compare 0 meets underflow
    ptag = "R3";
    chain = 1; rld0 = 8'h12; rld1 = 8'h53; cmp0 = 8'h00; cmp1 = 8'h00;
    pwen = 2'b10; cen = 2'b01; run = 2'b01; load = 2'b11; cyc();
    for (int i = 0; i < 400; i++) begin
      if (i == 5 || i == 200) rdn(0);
      if (i == 60 || i == 260) rdn(3);
      if (i == 90 || i == 300) rdn(1);
      if (i == 120 || i == 330) rdn(2);
      cyc();
    end
    rld0 = 8'h00; rld1 = 8'h00; load = 2'b11; cyc();
    for (int i = 0; i < 20; i++) cyc();

    // R10: leave and re-enter chain, read upper nibble first
    ptag = "R10";
    rld0 = 8'h9C; rld1 = 8'hE7; load = 2'b11; chain = 0; cyc();
    chain = 1; cyc();
    rdn(2); cyc(); rdn(3); cyc(); rdn(0); cyc();
    for (int i = 0; i < 10; i++) cyc();
    rdn(2); cyc(); cyc();

    // R4: event counting on falling edges
    ptag = "R4";
    chain = 0; evm = 2'b01; evf = 2'b01; run = 2'b01; rld0 = 8'h07; load = 2'b01; cyc();
    for (int i = 0; i < 60; i++) begin
      if (i % 3 == 0) evt[0] = ~evt[0];
      if (i % 4 == 1) rdn(0);
      cyc();
    end

    // Random mix
    for (int i = 0; i < 20000; i++) begin
      if (i % 400 == 0) begin
        chain = 1'($urandom); run = 2'($urandom); evm = 2'($urandom); evf = 2'($urandom);
        pwen = 2'($urandom); pol = 2'($urandom); osel = 1'($urandom);
        rld0 = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 16);
        rld1 = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 16);
        cmp0 = 8'($urandom % 16); cmp1 = 8'($urandom % 16);
        ptag = chain ? "R3" : (evm != 0 ? "R4" : "R1");
      end
      cen = 2'($urandom);
      if ($urandom % 5 == 0) evt = evt ^ 2'($urandom);
      if ($urandom % 64 == 0) load = 2'($urandom);
      if ($urandom % 3 == 0) rdn(int'($urandom % 4));
      cyc();
    end
    finish_run();
  end
endmodule